// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port that sits on a simple register bus. Software sets the direction of each pin on its own, writes an output latch, and reads either the latch contents or the level seen on the pins. The pad is modelled as a data-out vector and an output-enable vector for tri-state drivers, with the inputs coming from two buffer models: a hysteresis buffer and a TTL-threshold buffer. The selected input is brought into the clock domain by a two-flop synchroniser before any read can see it.

The top three pins can be taken over by a PWM peripheral. A per-pin select replaces both the latch data and the output enable with values the peripheral supplies. A parallel-slave mode flag hands the port to an external host. In that mode the TTL input path is used, a host write strobe captures the synchronised pins into an input buffer, and a host read strobe drives the latch onto the pins. The PWM peripheral overrides the flag: whenever it runs in any multi-output mode, parallel-slave operation is switched off. The host handshake and the analog pad behaviour are not modelled.

Top module: `gpio_port_ovr`

## Requirements
- R1: A direction bit of 1 puts its pin in high impedance (`pad_oe` bit 0). A direction bit of 0 drives the latch bit on that pin (`pad_oe` bit 1, `pad_out` bit = latch bit). This applies to every pin that is neither overridden nor driven by a parallel-slave read.
- R2: The register addresses are: port = 0, latch = 1, direction = 2. A bus write to address 0 or address 1 loads `bus_wdata` into the output latch. A write to address 2 loads the direction register and leaves the latch unchanged.
- R3: A bus read of address 1 returns the latch value, whatever the pin levels are.
- R4: When parallel-slave mode is inactive, a bus read of address 0 returns the hysteresis-buffer input (`pin_st`) after two synchroniser flops. A change applied before two rising edges is not yet visible.
- R5: A bus read of address 2 returns the direction register. `bus_rdata` is zero whenever `bus_rd` is low or the address is 3.
- R6: After a synchronous reset, the direction register reads 0xFF, the latch reads 0x00 and `pad_oe` is 0x00.
- R7: Pins 7, 6 and 5 are selected by `ovr_sel` bits 2, 1 and 0. A selected pin takes `pad_out` from the matching `ovr_data` bit and `pad_oe` from the matching `ovr_oe` bit, whatever the direction and latch hold. The override ranks above a parallel-slave read.
- R8: The `pwm_mode` encoding is 0 = single output, 1 = dual (half-bridge), 2 = quad forward, 3 = quad reverse. `psp_active` is 1 only when `psp_mode_req` is 1 and `pwm_mode` is 0.
- R9: While `psp_active` is 1, the synchroniser is fed from `pin_ttl` instead of `pin_st`.
- R10: While `psp_active` is 1, a `psp_wr_stb` pulse captures the synchronised input into a host buffer, and a port read returns that buffer. When `psp_active` is 0, the strobe is ignored.
- R11: While `psp_active` is 1 and `psp_rd_stb` is 1, every pin that is not overridden is driven (`pad_oe` 1) with its latch bit, even if it is set as an input. When `psp_active` is 0, the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address (0 port, 1 latch, 2 direction) |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not reading |
| pin_st | input | 8 | Pin levels through the hysteresis buffer model |
| pin_ttl | input | 8 | Pin levels through the TTL buffer model |
| pad_out | output | 8 | Output data to the tri-state pad drivers |
| pad_oe | output | 8 | Output enable per pin, 1 = driving |
| ovr_sel | input | 3 | Peripheral takes over pins 7..5 |
| ovr_data | input | 3 | Peripheral output data for pins 7..5 |
| ovr_oe | input | 3 | Peripheral output enable for pins 7..5 |
| pwm_mode | input | 2 | PWM output mode of the peripheral |
| psp_mode_req | input | 1 | Parallel-slave mode flag |
| psp_wr_stb | input | 1 | Host write strobe |
| psp_rd_stb | input | 1 | Host read strobe |
| psp_active | output | 1 | Parallel-slave mode in effect |

## Verification
The bench drives pins that disagree with the latch. A design that returned pin levels on a latch read, or latch bits on a port read, therefore shows a wrong value at once. It reads a pin change after one edge and again after two, which catches a synchroniser that is too short or missing. It gives the two input buffers different values, so a swapped buffer select reads back the wrong pattern. It asks for parallel-slave mode in each multi-output PWM mode, and a design that failed to force the mode off would let the host read strobe drive every pin. It also overrides a pin set as input, with an override enable of 0 next to an enable of 1. This exposes a design that kept the direction bit, or the latch bit, on an overridden pin.

// File: rtl/gpio_port_pkg.sv
// Package: shared register address and PWM mode encodings for the GPIO port.
// Assumes a 2-bit register address bus.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        REG_PORT  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PWM_SINGLE   = 2'd0,
        PWM_HALF     = 2'd1,
        PWM_FULL_FWD = 2'd2,
        PWM_FULL_REV = 2'd3
    } pwm_mode_e;
endpackage

// File: rtl/gpio_regs.sv
// gpio_regs: holds the output latch and the direction register, and muxes the
// bus read data. Assumes single-cycle register access and a combinational read.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] port_rd_val,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] bus_rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    // Register writes: the port and latch addresses both load the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else if (bus_wr) begin
            case (sel)
                REG_PORT, REG_LATCH: latch_q <= bus_wdata;
                REG_DIR:             dir_q   <= bus_wdata;
                default:             ;
            endcase
        end
    end

    // Read mux: latch address gives the latch, port address the pin view.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_PORT:  bus_rdata = port_rd_val;
                REG_LATCH: bus_rdata = latch_q;
                REG_DIR:   bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// gpio_sync: a multi-stage flop synchroniser for the pin inputs. Assumes
// STAGES >= 2 and that each bit may be sampled on its own.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the asynchronous pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages let metastability settle.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
// gpio_pin_mux: per-pin output data and enable selection. Pins at or above
// OVR_LO can be taken over by a peripheral. Assumes OVR_LO < WIDTH. Priority:
// peripheral override, then host read drive, then direction/latch.
module gpio_pin_mux #(
    parameter int WIDTH  = 8,
    parameter int OVR_LO = 5,
    localparam int NOVR  = WIDTH - OVR_LO
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [NOVR-1:0]  ovr_sel,
    input  logic [NOVR-1:0]  ovr_data,
    input  logic [NOVR-1:0]  ovr_oe,
    input  logic             host_drive,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic base_oe;
        assign base_oe = host_drive | ~dir_q[i];
        if (i >= OVR_LO) begin : g_ovr
            // Peripheral override replaces both data and enable.
            always_comb begin
                if (ovr_sel[i-OVR_LO]) begin
                    pad_out[i] = ovr_data[i-OVR_LO];
                    pad_oe[i]  = ovr_oe[i-OVR_LO];
                end else begin
                    pad_out[i] = latch_q[i];
                    pad_oe[i]  = base_oe;
                end
            end
        end else begin : g_plain
            // Plain pin: latch data, enable from direction or host drive.
            always_comb begin
                pad_out[i] = latch_q[i];
                pad_oe[i]  = base_oe;
            end
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
// gpio_port_ovr: 8-bit bidirectional I/O port with peripheral override on the
// upper pins and a parallel-slave mode. Assumes pin inputs are asynchronous and
// that the PWM mode and the mode flag are quasi-static.
module gpio_port_ovr
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int OVR_LO      = 5,
    parameter int SYNC_STAGES = 2,
    localparam int NOVR       = WIDTH - OVR_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_st,
    input  logic [WIDTH-1:0] pin_ttl,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [NOVR-1:0]  ovr_sel,
    input  logic [NOVR-1:0]  ovr_data,
    input  logic [NOVR-1:0]  ovr_oe,
    input  logic [1:0]       pwm_mode,
    input  logic             psp_mode_req,
    input  logic             psp_wr_stb,
    input  logic             psp_rd_stb,
    output logic             psp_active
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] in_sel;
    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] host_buf;
    logic [WIDTH-1:0] port_rd_val;

    // Any multi-output PWM mode forces parallel-slave mode off.
    assign psp_active = psp_mode_req && (pwm_mode_e'(pwm_mode) == PWM_SINGLE);

    // Input buffer choice: TTL path in parallel-slave mode, hysteresis path otherwise.
    assign in_sel = psp_active ? pin_ttl : pin_st;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_sel),
        .q     (in_sync)
    );

    // Host write strobe captures the synchronised input in parallel-slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                       host_buf <= '0;
        else if (psp_active && psp_wr_stb) host_buf <= in_sync;
    end

    assign port_rd_val = psp_active ? host_buf : in_sync;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .port_rd_val (port_rd_val),
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .bus_rdata   (bus_rdata)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .OVR_LO(OVR_LO)) u_mux (
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .ovr_sel    (ovr_sel),
        .ovr_data   (ovr_data),
        .ovr_oe     (ovr_oe),
        .host_drive (psp_active & psp_rd_stb),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// gpio_port_chk: property checker for gpio_port_ovr, attached by bind.
// Assumes the bound instance exposes latch_q and dir_q.
module gpio_port_chk #(
    parameter int WIDTH  = 8,
    parameter int OVR_LO = 5,
    localparam int NOVR  = WIDTH - OVR_LO
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [NOVR-1:0]  ovr_sel,
    input logic [1:0]       pwm_mode,
    input logic             psp_mode_req,
    input logic             psp_rd_stb,
    input logic             psp_active,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] ovr_mask;
    assign ovr_mask = {ovr_sel, {OVR_LO{1'b0}}};

    // R1: input pins float, output pins drive, outside override and host drive.
    a_r1_dir_controls_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !(psp_active && psp_rd_stb) |-> ((pad_oe & ~ovr_mask) == (~dir_q & ~ovr_mask)));

    // R2: a write to the port or latch address lands in the latch.
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> (latch_q == $past(bus_wdata)));

    // R3: a latch read returns the latch.
    a_r3_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |-> (bus_rdata == latch_q));

    // R5: no read, no data.
    a_r5_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R6: reset leaves every pin an input.
    a_r6_reset_dir: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '1));

    // R7: without override or host drive, pad data follows the latch.
    a_r7_no_ovr_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_sel == '0) |-> (pad_out == latch_q));

    // R8: multi-output PWM forces parallel-slave off; single mode honours the flag.
    a_r8_pwm_blocks_psp: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode != 2'd0) |-> !psp_active);
    a_r8_flag_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'd0 && psp_mode_req) |-> psp_active);
endmodule

bind gpio_port_ovr gpio_port_chk #(.WIDTH(WIDTH), .OVR_LO(OVR_LO)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ovr_sel      (ovr_sel),
    .pwm_mode     (pwm_mode),
    .psp_mode_req (psp_mode_req),
    .psp_rd_stb   (psp_rd_stb),
    .psp_active   (psp_active),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .latch_q      (latch_q),
    .dir_q        (dir_q)
);

// File: tb/tb_gpio_port_ovr.sv
module tb_gpio_port_ovr;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_st = '0;
    logic [7:0] pin_ttl = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [2:0] ovr_sel = '0;
    logic [2:0] ovr_data = '0;
    logic [2:0] ovr_oe = '0;
    logic [1:0] pwm_mode = '0;
    logic       psp_mode_req = 1'b0;
    logic       psp_wr_stb = 1'b0;
    logic       psp_rd_stb = 1'b0;
    logic       psp_active;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    gpio_port_ovr dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_st(pin_st), .pin_ttl(pin_ttl), .pad_out(pad_out), .pad_oe(pad_oe),
        .ovr_sel(ovr_sel), .ovr_data(ovr_data), .ovr_oe(ovr_oe),
        .pwm_mode(pwm_mode), .psp_mode_req(psp_mode_req),
        .psp_wr_stb(psp_wr_stb), .psp_rd_stb(psp_rd_stb), .psp_active(psp_active)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] latch;
        logic [7:0] pins;
        logic [7:0] exp_oe;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h00, 8'hA5, 8'h3C, 8'hFF},
        '{8'hFF, 8'h5A, 8'h0F, 8'h00},
        '{8'hCF, 8'hFF, 8'h81, 8'h30},
        '{8'h0F, 8'h96, 8'hF0, 8'hF0},
        '{8'hAA, 8'h01, 8'hFE, 8'h55}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);

        // R6: reset state
        check("R6 reset pad_oe", pad_oe, 8'h00);
        bus_read(2'd2, r); check("R6 reset dir", r, 8'hFF);
        bus_read(2'd1, r); check("R6 reset latch", r, 8'h00);
        // R5: idle read data is zero
        check("R5 idle rdata", bus_rdata, 8'h00);

        // Vector table: R1, R2, R3, R4, R5
        for (int v = 0; v < 5; v++) begin
            bus_write(2'd2, VECS[v].dir);
            bus_write((v % 2 == 0) ? 2'd0 : 2'd1, VECS[v].latch);
            @(negedge clk); pin_st = VECS[v].pins; pin_ttl = ~VECS[v].pins;
            wait_edges(3);
            check("R1 pad_oe", pad_oe, VECS[v].exp_oe);
            check("R1 pad_out", pad_out, VECS[v].latch);
            bus_read(2'd1, r); check("R3 latch read", r, VECS[v].latch);
            bus_read(2'd0, r); check("R4 port read", r, VECS[v].pins);
            bus_read(2'd2, r); check("R5 dir read", r, VECS[v].dir);
        end

        // R2: direction write leaves latch alone; address 3 reads zero (R5)
        bus_write(2'd1, 8'h3C);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, r); check("R2 dir write keeps latch", r, 8'h3C);
        bus_write(2'd3, 8'hEE);
        bus_read(2'd3, r); check("R5 unused address", r, 8'h00);
        bus_read(2'd1, r); check("R2 unused write ignored", r, 8'h3C);

        // R4: two-flop latency
        @(negedge clk); pin_st = 8'h00;
        wait_edges(3);
        @(negedge clk); pin_st = 8'h77;
        bus_read(2'd0, r); check("R4 after one edge", r, 8'h00);
        bus_read(2'd0, r); check("R4 after two edges", r, 8'h77);

        // R7: override pins 7 and 5, pin 7 released, pin 5 driven
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'h00);
        @(negedge clk); ovr_sel = 3'b101; ovr_data = 3'b111; ovr_oe = 3'b011;
        #1;
        check("R7 override out", pad_out, 8'hA0);
        check("R7 override oe", pad_oe, 8'h7F);
        // R7: override on an input pin still drives
        bus_write(2'd2, 8'hFF);
        #1 check("R7 override beats dir", pad_oe, 8'h20);
        @(negedge clk); ovr_sel = '0; ovr_data = '0; ovr_oe = '0;

        // R9, R10: parallel-slave mode uses TTL path and host buffer
        @(negedge clk); pin_st = 8'h11; pin_ttl = 8'h22;
        wait_edges(3);
        bus_read(2'd0, r); check("R9 normal uses hysteresis path", r, 8'h11);
        @(negedge clk); psp_mode_req = 1'b1;
        #1 check("R8 flag honoured", {7'd0, psp_active}, 8'h01);
        bus_read(2'd0, r); check("R10 buffer before strobe", r, 8'h00);
        wait_edges(3);
        @(negedge clk); psp_wr_stb = 1'b1;
        @(negedge clk); psp_wr_stb = 1'b0;
        bus_read(2'd0, r); check("R9 R10 TTL captured", r, 8'h22);

        // R11: host read drives latch on all pins
        bus_write(2'd1, 8'hC3);
        @(negedge clk); psp_rd_stb = 1'b1;
        #1;
        check("R11 host drive oe", pad_oe, 8'hFF);
        check("R11 host drive out", pad_out, 8'hC3);
        // R7: override still ranks above host drive
        ovr_sel = 3'b100; ovr_oe = 3'b000; ovr_data = 3'b000;
        #1 check("R7 override above host", pad_oe, 8'h7F);
        ovr_sel = '0;
        @(negedge clk); psp_rd_stb = 1'b0;

        // R8: every multi-output mode disables parallel-slave
        for (int m = 1; m < 4; m++) begin
            @(negedge clk); pwm_mode = 2'(m); psp_rd_stb = 1'b1;
            #1;
            check("R8 multi-output disables", {7'd0, psp_active}, 8'h00);
            check("R11 strobe ignored when inactive", pad_oe, 8'h00);
        end
        @(negedge clk); psp_rd_stb = 1'b0;
        wait_edges(3);
        bus_read(2'd0, r); check("R9 R4 back to hysteresis path", r, 8'h11);
        // R10: write strobe ignored while inactive
        @(negedge clk); pin_ttl = 8'h55; pin_st = 8'h55;
        wait_edges(3);
        @(negedge clk); psp_wr_stb = 1'b1;
        @(negedge clk); psp_wr_stb = 1'b0; pwm_mode = 2'd0; pin_ttl = 8'h66;
        bus_read(2'd0, r); check("R10 strobe ignored when inactive", r, 8'h22);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule